// File: doc/BRIEF.md
# ALU Operand-Management Computation Unit

This unit sits between an issue stage and one arithmetic unit. An operation is handed over with a one-cycle issue strobe. In that cycle the unit captures the opcode, the operand-modifier flags, the immediate value and the per-port skip mask. From the next cycle on it holds `busy` high until the result has been written back. Both register source operands are fetched with their own request/grant handshake. Ports whose operand is substituted or masked never raise a request. Operand A can be forced to zero or complemented, and operand B can be replaced by the immediate.

Once every needed operand has been captured, the unit offers the operands to an internal arithmetic unit over a valid/ready interface. Add, multiply and shift-right take a parameterised number of cycles. Subtract answers in the same cycle when the combinational variant is selected. The unit stores the result, raises a write request with the result on `wr_data`, and returns to idle one cycle after a one-cycle write grant.

Top module: `alu_opunit`

## Requirements
- R1: `busy` is low in the cycle in which an accepted `issue` is high. It is high from the following cycle until the cycle after the write grant, and it never rises without a preceding issue.
- R2: `op_code`, `op_inv_a`, `op_zero_a`, `op_imm`, `op_imm_vld` and `rd_skip` are captured in the issue cycle. Changing them afterwards does not change the result.
- R3: A needed read port raises `rd_req[p]` in the cycle after issue. The request then stays high for any number of cycles until `rd_grant[p]` arrives.
- R4: A grant may arrive in the same cycle the request rises. The operand on `src_a` (port 0) or `src_b` (port 1) is captured in the grant cycle. The request is low in the next cycle and stays low for the rest of the busy period.
- R5: Port 0 raises no request when `op_zero_a` is set. Port 1 raises no request when `op_imm_vld` is set. Port p raises no request when `rd_skip[p]` is 1, and its operand is then taken as zero.
- R6: The operand A seen by the arithmetic unit is 0 when `op_zero_a` is set. Otherwise it is the bitwise complement of A when `op_inv_a` is set, and A itself when not. Operand B is `op_imm` when `op_imm_vld` is set.
- R7: `op_code` 0 adds, 1 subtracts (A-B, zero latency), 2 multiplies (low W bits) and 3 shifts A right by the low log2(W) bits of B. Add, multiply and shift take LAT cycles.
- R8: When the result is ready, `wr_req` is high with the result on `wr_data`. After the cycle in which `wr_grant` is high, both `wr_req` and `busy` are low.
- R9: An `issue` pulse while `busy` is high is ignored and does not change the running operation.
- R10: A synchronous active-high `rst` clears `busy`, all read requests, `wr_req` and `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | One-cycle operation strobe |
| op_code | input | 2 | Operation select |
| op_inv_a | input | 1 | Complement operand A |
| op_zero_a | input | 1 | Force operand A to zero |
| op_imm | input | W | Immediate value |
| op_imm_vld | input | 1 | Use immediate as operand B |
| rd_skip | input | 2 | Per-port read suppression |
| rd_req | output | 2 | Read requests, bit 0 = A, bit 1 = B |
| rd_grant | input | 2 | One-cycle read grants |
| src_a | input | W | Operand A data |
| src_b | input | W | Operand B data |
| wr_req | output | 1 | Write-back request |
| wr_grant | input | 1 | One-cycle write grant |
| wr_data | output | W | Result |
| busy | output | 1 | Operation in flight |

## Verification
Two pairs of functions can land in the same cycle. The first is the rise of a read request and its grant. The bench provokes this by granting in the first cycle the request is visible, and judges it by the captured operand appearing in the result and the request being low one cycle later. The second is the operand hand-over and the result return of a zero-latency subtract, which happen in one cycle. Subtract vectors check that the result is correct and that write-back still follows.

// File: rtl/opunit_pkg.sv
package opunit_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_MUL = 2'd2,
      OP_SHR = 2'd3
   } opcode_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_READ  = 2'd1,
      S_EXEC  = 2'd2,
      S_WRITE = 2'd3
   } unit_state_e;

   localparam int unsigned NUM_RD = 2;

endpackage

// File: rtl/opunit_rdport.sv
module opunit_rdport #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         need,
   input  logic         grant,
   input  logic [W-1:0] src,
   output logic         req,
   output logic         done,
   output logic [W-1:0] value
);
   logic         req_q;
   logic         done_q;
   logic [W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q  <= 1'b0;
         done_q <= 1'b0;
         val_q  <= '0;
      end else if (start) begin
         req_q  <= need;
         done_q <= ~need;
         val_q  <= '0;
      end else if (req_q && grant) begin
         req_q  <= 1'b0;
         done_q <= 1'b1;
         val_q  <= src;
      end
   end

   assign req   = req_q;
   assign done  = done_q;
   assign value = val_q;
endmodule

// File: rtl/opunit_alu.sv
module opunit_alu
   import opunit_pkg::*;
#(
   parameter int unsigned W        = 16,
   parameter int unsigned LAT      = 3,
   parameter bit          COMB_SUB = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  opcode_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         in_valid,
   output logic         in_ready,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   localparam int unsigned SHW = $clog2(W);
   localparam int unsigned CW  = $clog2(LAT + 1);

   logic [W-1:0]   fn_res;
   logic [2*W-1:0] prod;
   logic           zero_lat;
   logic           run_q;
   logic [CW-1:0]  cnt_q;
   logic [W-1:0]   res_q;

   assign prod = a * b;

   always_comb begin
      unique case (op)
         OP_ADD:  fn_res = a + b;
         OP_SUB:  fn_res = a - b;
         OP_MUL:  fn_res = prod[W-1:0];
         default: fn_res = a >> b[SHW-1:0];
      endcase
   end

   generate
      if (COMB_SUB) begin : g_comb_sub
         assign zero_lat = (op == OP_SUB);
      end else begin : g_seq_sub
         assign zero_lat = 1'b0;
      end
   endgenerate

   assign in_ready  = ~run_q & (zero_lat ? out_ready : 1'b1);
   assign out_valid = run_q ? (cnt_q == '0) : (in_valid & zero_lat);
   assign out_data  = run_q ? res_q : fn_res;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         res_q <= '0;
      end else if (!run_q) begin
         if (in_valid && !zero_lat) begin
            run_q <= 1'b1;
            cnt_q <= CW'(LAT - 1);
            res_q <= fn_res;
         end
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (out_ready) begin
         run_q <= 1'b0;
      end
   end
endmodule

// File: rtl/alu_opunit.sv
module alu_opunit
   import opunit_pkg::*;
#(
   parameter int unsigned W        = 16,
   parameter int unsigned LAT      = 3,
   parameter bit          COMB_SUB = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         issue,
   input  logic [1:0]   op_code,
   input  logic         op_inv_a,
   input  logic         op_zero_a,
   input  logic [W-1:0] op_imm,
   input  logic         op_imm_vld,
   input  logic [1:0]   rd_skip,
   output logic [1:0]   rd_req,
   input  logic [1:0]   rd_grant,
   input  logic [W-1:0] src_a,
   input  logic [W-1:0] src_b,
   output logic         wr_req,
   input  logic         wr_grant,
   output logic [W-1:0] wr_data,
   output logic         busy
);
   generate
      if (W < 4) begin : g_bad_width
         $error("alu_opunit: W must be at least 4");
      end
      if (LAT < 1) begin : g_bad_lat
         $error("alu_opunit: LAT must be at least 1");
      end
   endgenerate

   unit_state_e st_q;
   opcode_e     op_q;
   logic        inv_q, zero_q, immv_q, sent_q;
   logic [W-1:0] imm_q, res_q;
   logic [NUM_RD-1:0] skip_q, subst, need, done;
   logic [W-1:0] src [NUM_RD];
   logic [W-1:0] val [NUM_RD];
   logic         start;
   logic [W-1:0] alu_a, alu_b, alu_out;
   logic         alu_iv, alu_ir, alu_ov, alu_or;

   assign start = issue & (st_q == S_IDLE);
   assign src[0] = src_a;
   assign src[1] = src_b;

   // substitution decided from the fields of the issue cycle
   assign subst[0] = start ? op_zero_a  : zero_q;
   assign subst[1] = start ? op_imm_vld : immv_q;
   assign need     = ~subst & ~(start ? rd_skip : skip_q);

   generate
      for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
         opunit_rdport #(.W(W)) u_port (
            .clk   (clk),
            .rst   (rst),
            .start (start),
            .need  (need[p]),
            .grant (rd_grant[p]),
            .src   (src[p]),
            .req   (rd_req[p]),
            .done  (done[p]),
            .value (val[p])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q   <= OP_ADD;
         inv_q  <= 1'b0;
         zero_q <= 1'b0;
         immv_q <= 1'b0;
         imm_q  <= '0;
         skip_q <= '0;
      end else if (start) begin
         op_q   <= opcode_e'(op_code);
         inv_q  <= op_inv_a;
         zero_q <= op_zero_a;
         immv_q <= op_imm_vld;
         imm_q  <= op_imm;
         skip_q <= rd_skip;
      end
   end

   always_comb begin
      if (zero_q)     alu_a = '0;
      else if (inv_q) alu_a = ~val[0];
      else            alu_a = val[0];
      alu_b = immv_q ? imm_q : val[1];
   end

   assign alu_iv = (st_q == S_EXEC) & ~sent_q;
   assign alu_or = (st_q == S_EXEC);

   opunit_alu #(.W(W), .LAT(LAT), .COMB_SUB(COMB_SUB)) u_alu (
      .clk       (clk),
      .rst       (rst),
      .op        (op_q),
      .a         (alu_a),
      .b         (alu_b),
      .in_valid  (alu_iv),
      .in_ready  (alu_ir),
      .out_valid (alu_ov),
      .out_ready (alu_or),
      .out_data  (alu_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= S_IDLE;
         sent_q <= 1'b0;
         res_q  <= '0;
      end else begin
         unique case (st_q)
            S_IDLE:  if (issue) st_q <= S_READ;
            S_READ:  if (&done) st_q <= S_EXEC;
            S_EXEC: begin
               if (alu_iv && alu_ir) sent_q <= 1'b1;
               if (alu_ov) begin
                  res_q  <= alu_out;
                  sent_q <= 1'b0;
                  st_q   <= S_WRITE;
               end
            end
            default: if (wr_grant) st_q <= S_IDLE;
         endcase
      end
   end

   assign busy    = (st_q != S_IDLE);
   assign wr_req  = (st_q == S_WRITE);
   assign wr_data = res_q;
endmodule

// File: rtl/opunit_chk.sv
module opunit_chk #(
   parameter int unsigned W = 16
) (
   input logic         clk,
   input logic         rst,
   input logic         issue,
   input logic         busy,
   input logic [1:0]   rd_req,
   input logic [1:0]   rd_grant,
   input logic         wr_req,
   input logic         wr_grant,
   input logic [W-1:0] wr_data
);
   // R1
   busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(issue));

   // R1
   issue_start_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && issue) |=> busy);

   generate
      for (genvar p = 0; p < 2; p++) begin : g_port
         // R3
         req_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_req[p] && !rd_grant[p]) |=> rd_req[p]);
         // R4
         req_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_req[p] && rd_grant[p]) |=> !rd_req[p]);
         // R3
         req_busy_chk: assert property (@(posedge clk) disable iff (rst)
            rd_req[p] |-> busy);
      end
   endgenerate

   // R8
   wr_busy_chk: assert property (@(posedge clk) disable iff (rst)
      wr_req |-> busy);

   // R8
   wr_done_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_req && wr_grant) |=> (!busy && !wr_req));

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!busy && rd_req == 2'b00 && !wr_req && wr_data == '0));
endmodule

bind alu_opunit opunit_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .issue    (issue),
   .busy     (busy),
   .rd_req   (rd_req),
   .rd_grant (rd_grant),
   .wr_req   (wr_req),
   .wr_grant (wr_grant),
   .wr_data  (wr_data)
);

// File: tb/alu_opunit_tb.sv
module alu_opunit_tb;
   localparam int unsigned W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         issue = 1'b0;
   logic [1:0]   op_code = '0;
   logic         op_inv_a = 1'b0, op_zero_a = 1'b0, op_imm_vld = 1'b0;
   logic [W-1:0] op_imm = '0;
   logic [1:0]   rd_skip = '0;
   logic [1:0]   rd_req;
   logic [1:0]   rd_grant = '0;
   logic [W-1:0] src_a = '0, src_b = '0;
   logic         wr_req;
   logic         wr_grant = 1'b0;
   logic [W-1:0] wr_data;
   logic         busy;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   alu_opunit #(.W(W), .LAT(3), .COMB_SUB(1'b1)) u_dut (
      .clk(clk), .rst(rst), .issue(issue), .op_code(op_code),
      .op_inv_a(op_inv_a), .op_zero_a(op_zero_a), .op_imm(op_imm),
      .op_imm_vld(op_imm_vld), .rd_skip(rd_skip), .rd_req(rd_req),
      .rd_grant(rd_grant), .src_a(src_a), .src_b(src_b), .wr_req(wr_req),
      .wr_grant(wr_grant), .wr_data(wr_data), .busy(busy)
   );

   typedef struct packed {
      logic [15:0] a;
      logic [15:0] b;
      logic [1:0]  op;
      logic        inv;
      logic        zero;
      logic [15:0] imm;
      logic        immv;
      logic [1:0]  skip;
      logic [3:0]  d0;
      logic [3:0]  d1;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 11;
   // op: 0 add, 1 sub, 2 mul, 3 shr  (R7)
   localparam vec_t VECS [NV] = '{
      '{16'd5,  16'd2, 2'd0, 1'b0, 1'b0, 16'd8, 1'b1, 2'b00, 4'd0, 4'd0, 16'd13},
      '{16'd5,  16'd2, 2'd0, 1'b0, 1'b0, 16'd0, 1'b0, 2'b00, 4'd0, 4'd0, 16'd7},
      '{16'd5,  16'd2, 2'd0, 1'b1, 1'b0, 16'd0, 1'b0, 2'b00, 4'd1, 4'd0, 16'd65532},
      '{16'd5,  16'd2, 2'd0, 1'b0, 1'b1, 16'd8, 1'b1, 2'b00, 4'd0, 4'd0, 16'd8},
      '{16'd5,  16'd2, 2'd0, 1'b0, 1'b1, 16'd0, 1'b0, 2'b00, 4'd0, 4'd2, 16'd2},
      '{16'd5,  16'd2, 2'd1, 1'b0, 1'b0, 16'd0, 1'b0, 2'b00, 4'd0, 4'd0, 16'd3},
      '{16'd7,  16'd6, 2'd2, 1'b0, 1'b0, 16'd0, 1'b0, 2'b00, 4'd0, 4'd3, 16'd42},
      '{16'h80, 16'd3, 2'd3, 1'b0, 1'b0, 16'd0, 1'b0, 2'b00, 4'd2, 4'd0, 16'h10},
      '{16'd4,  16'd9, 2'd0, 1'b0, 1'b0, 16'd0, 1'b0, 2'b01, 4'd0, 4'd0, 16'd9},
      '{16'd4,  16'd9, 2'd1, 1'b0, 1'b0, 16'd0, 1'b0, 2'b11, 4'd0, 4'd0, 16'd0},
      '{16'd2,  16'd5, 2'd1, 1'b0, 1'b0, 16'd0, 1'b0, 2'b00, 4'd4, 4'd4, 16'hFFFD}
   };

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic run_op(input vec_t v, input logic reissue);
      logic [1:0] need, granted;
      int waited [2];
      logic got;
      need[0] = ~v.zero & ~v.skip[0];
      need[1] = ~v.immv & ~v.skip[1];
      granted = 2'b00;
      waited[0] = 0;
      waited[1] = 0;
      got = 1'b0;
      @(negedge clk);
      op_code = v.op; op_inv_a = v.inv; op_zero_a = v.zero;
      op_imm = v.imm; op_imm_vld = v.immv; rd_skip = v.skip;
      issue = 1'b1;
      check(busy == 1'b0, "R1 busy low in issue cycle", 32'(busy), 0);
      @(posedge clk);
      @(negedge clk);
      issue = 1'b0;
      // R2: scramble captured fields after issue
      op_code = ~v.op; op_inv_a = ~v.inv; op_zero_a = ~v.zero;
      op_imm = ~v.imm; op_imm_vld = ~v.immv; rd_skip = ~v.skip;
      check(busy == 1'b1, "R1 busy after issue", 32'(busy), 1);
      check(rd_req == need, "R3/R5 requests after issue", 32'(rd_req), 32'(need));
      for (int cyc = 0; cyc < 60; cyc++) begin
         rd_grant = 2'b00;
         src_a = 16'hDEAD;
         src_b = 16'hBEEF;
         if (reissue) issue = (cyc == 1);
         if (wr_req) begin
            got = 1'b1;
            break;
         end
         for (int p = 0; p < 2; p++) begin
            if (rd_req[p] && (granted[p] || !need[p]))
               check(1'b0, "R4/R5 request raised when not allowed", 32'(rd_req), 32'(need & ~granted));
            else if (rd_req[p]) begin
               if (waited[p] >= int'(p == 0 ? v.d0 : v.d1)) begin
                  rd_grant[p] = 1'b1;
                  granted[p] = 1'b1;
                  if (p == 0) src_a = v.a; else src_b = v.b;
               end else waited[p]++;
            end else if (need[p] && !granted[p])
               check(1'b0, "R3 request dropped before grant", 32'(rd_req), 32'(need));
         end
         @(posedge clk);
         @(negedge clk);
      end
      issue = 1'b0;
      check(got, "R8 write request reached", 32'(got), 1);
      check(granted == need, "R4 all needed ports granted", 32'(granted), 32'(need));
      check(wr_data == v.exp, "R6/R7 result", 32'(wr_data), 32'(v.exp));
      check(busy == 1'b1, "R1 busy during write request", 32'(busy), 1);
      wr_grant = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_grant = 1'b0;
      check(busy == 1'b0 && wr_req == 1'b0, "R8 release after write grant",
            {30'd0, busy, wr_req}, 0);
      check(rd_req == 2'b00, "R4 no request after busy period", 32'(rd_req), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      vec_t dv;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      check(busy == 0 && rd_req == 0 && wr_req == 0 && wr_data == 0,
            "R10 reset state", {wr_data, 13'd0, busy, rd_req}, 0);
      rst = 1'b0;
      @(negedge clk);
      check(busy == 1'b0, "R1 busy does not rise without issue", 32'(busy), 0);

      for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0);

      // R9: issue pulsed while busy is ignored
      dv = VECS[1];
      dv.d0 = 4'd3;
      run_op(dv, 1'b1);
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R9 stray issue did not start an operation", 32'(busy), 0);

      // R10: reset in the middle of an operation, after a completed one
      @(negedge clk);
      op_code = 2'd0; op_inv_a = 0; op_zero_a = 0; op_imm_vld = 0; rd_skip = 2'b00;
      issue = 1'b1;
      @(negedge clk);
      issue = 1'b0;
      check(rd_req == 2'b11, "R3 both requests pending", 32'(rd_req), 3);
      rst = 1'b1;
      @(negedge clk);
      check(busy == 0 && rd_req == 0 && wr_req == 0 && wr_data == 0,
            "R10 reset mid-operation", {wr_data, 13'd0, busy, rd_req}, 0);
      rst = 1'b0;
      run_op(VECS[5], 1'b0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule